// File: doc/BRIEF.md
# Serial Configuration Write Port

This block takes configuration words over a three-wire serial link (a serial clock, a data line and an active-low framing strobe) and keeps them in four 32-bit registers. The strobe falling edge opens a frame. While the strobe is low, each rising serial clock edge shifts one data bit in, most significant bit first. The strobe rising edge closes the frame. If exactly 32 bits arrived, the low two bits of the shifted word select the target register and the whole word is stored there. A frame of any other length is dropped.

Each stored word crosses into the system clock domain as a whole. A toggle flag marks the new word. Two synchronizer flops and an edge detector turn that toggle into a one-cycle update pulse, and the target register is written on that pulse. The block decodes the stored words into named outputs: two 10-bit divider codes, where code Q-1 selects ratio Q; two 3-bit delay codes; a pulse-width code; a charge-pump current code; five output enables; a pump enable and an amplifier enable; a feedback selector; five 3-bit output divider selectors; pump direction; external resistor select; hold enable; active-low soft power-down and soft reset; reference enable; and a 2-bit lock-window code. Register 3 is reserved for test use. It accepts writes, but no output depends on it.

Top module: `lecfg_port`

## Requirements
- R1: After reset, the outputs hold these values:
  - Both divider codes are 127, which selects divide-by-128.
  - Both delays, the pulse-width code, amp_en, ext_res_en, hold_en and lock_win are 0.
  - The pump code is 9.
  - All five output enables are 1, and pump_en is 1.
  - fb_sel is 3.
  - out_sel, from output 0 to output 4, is 0, 1, 2, 3, 3.
  - pump_dir, soft_pd_n, soft_rst_n and bg_en are 1.
- R2: A 32-bit frame whose bits [1:0] are 0 writes register 0. The first bit shifted in lands in bit 31. The outputs then read:
  - ref_div_code from [11:2] and ref_dly from [14:12].
  - pw_code from [17:15] and pump_code from [21:18].
  - out_en from [26:22], pump_en from bit 27 and amp_en from bit 28.
  - fb_sel from [31:29].
- R3: A frame with bits [1:0] equal to 1 writes register 1. The outputs then read:
  - fb_div_code from [11:2] and fb_dly from [14:12].
  - out_sel from [29:15], where output n takes bits [15+3n+2:15+3n].
  - pump_dir from bit 30 and ext_res_en from bit 31.
- R4: A frame with bits [1:0] equal to 2 writes register 2. The outputs then read hold_en from bit 2, soft_pd_n from bit 3, soft_rst_n from bit 4, bg_en from bit 5 and lock_win from [7:6]. The power-down and reset bits pass through raw: a value of 0 means the function is asserted.
- R5: A write changes only the register its address bits select. Fields of the other registers keep their values.
- R6: A frame with bits [1:0] equal to 3 changes no output.
- R7: A frame that closes after 0, 31 or 33 bits, or any count other than 32, changes no output.
- R8: Serial clock edges while the strobe is high change no output.
- R9: A word's fields are not yet visible one system clock cycle after the strobe rising edge. They are visible within six system clock cycles.
- R10: A frame that opens right after the previous strobe rising edge, and shifts while the previous word is still crossing into the system domain, does not disturb that word. Both words are stored.
- R11: Divider codes 0 (ratio 1) and 1023 (ratio 1024) pass to the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, data sampled on rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_le_n | input | 1 | Active-low frame strobe |
| ref_div_code | output | 10 | Reference divider code (ratio - 1) |
| ref_dly | output | 3 | Reference path delay code |
| pw_code | output | 3 | Phase detector pulse-width code |
| pump_code | output | 4 | Charge-pump current code |
| out_en | output | 5 | Per-output enables |
| pump_en | output | 1 | Charge-pump output enable |
| amp_en | output | 1 | Loop amplifier enable |
| fb_sel | output | 3 | Feedback tap selector |
| fb_div_code | output | 10 | Feedback divider code (ratio - 1) |
| fb_dly | output | 3 | Feedback path delay code |
| out_sel | output | 15 | Five 3-bit output divider selectors |
| pump_dir | output | 1 | Charge-pump polarity |
| ext_res_en | output | 1 | External bias resistor select |
| hold_en | output | 1 | Hold function enable |
| soft_pd_n | output | 1 | Soft power-down, active low |
| soft_rst_n | output | 1 | Soft divider reset, active low |
| bg_en | output | 1 | Reference generator enable |
| lock_win | output | 2 | Lock-detect window code |

## Verification
The system-domain commit of one word can fall in the same cycles as the serial shifting of the next frame. The bench provokes this by opening a second frame for a different register one serial half-period after the first strobe rising edge, so the update pulse fires while new bits are being shifted. Both registers must then show their own words, with no bits taken from the other frame. The commit latency is checked at both ends: the outputs must still show the old values on the first system clock cycle after the strobe rises, and the new values within six cycles.

// File: rtl/lecfg_pkg.sv
package lecfg_pkg;

  localparam int CFG_WORD_W   = 32;
  localparam int CFG_NUM_REGS = 4;
  localparam int CFG_ADDR_W   = $clog2(CFG_NUM_REGS);
  localparam int CFG_RSVD_IDX = CFG_NUM_REGS - 1;

  localparam int CFG_DIV_W    = 10;
  localparam int CFG_DLY_W    = 3;
  localparam int CFG_PW_W     = 3;
  localparam int CFG_PUMP_W   = 4;
  localparam int CFG_NUM_OUT  = 5;
  localparam int CFG_SEL_W    = 3;
  localparam int CFG_LW_W     = 2;

  // shared layout of registers 0 and 1
  localparam int DIV_LSB      = CFG_ADDR_W;
  localparam int DLY_LSB      = DIV_LSB + CFG_DIV_W;

  // register 0 layout
  localparam int PW_LSB       = DLY_LSB + CFG_DLY_W;
  localparam int PUMP_LSB     = PW_LSB + CFG_PW_W;
  localparam int OE_LSB       = PUMP_LSB + CFG_PUMP_W;
  localparam int PEN_BIT      = OE_LSB + CFG_NUM_OUT;
  localparam int AEN_BIT      = PEN_BIT + 1;
  localparam int FBSEL_LSB    = AEN_BIT + 1;

  // register 1 layout
  localparam int OSEL_LSB     = DLY_LSB + CFG_DLY_W;
  localparam int DIR_BIT      = OSEL_LSB + CFG_NUM_OUT * CFG_SEL_W;
  localparam int REXT_BIT     = DIR_BIT + 1;

  // register 2 layout
  localparam int HOLD_BIT     = CFG_ADDR_W;
  localparam int PD_BIT       = HOLD_BIT + 1;
  localparam int SRST_BIT     = PD_BIT + 1;
  localparam int BG_BIT       = SRST_BIT + 1;
  localparam int LW_LSB       = BG_BIT + 1;

  typedef enum logic [CFG_ADDR_W-1:0] {
    REG_REF  = 2'd0,
    REG_FB   = 2'd1,
    REG_MISC = 2'd2,
    REG_TEST = 2'd3
  } cfg_reg_e;

  function automatic logic [CFG_WORD_W-1:0] cfg_default(input int unsigned idx);
    logic [CFG_WORD_W-1:0] w;
    w = '0;
    case (idx)
      0: begin
        w[DIV_LSB +: CFG_DIV_W]              = CFG_DIV_W'(127);
        w[PUMP_LSB +: CFG_PUMP_W]            = CFG_PUMP_W'(9);
        w[OE_LSB +: CFG_NUM_OUT]             = '1;
        w[PEN_BIT]                           = 1'b1;
        w[FBSEL_LSB +: CFG_SEL_W]            = CFG_SEL_W'(3);
      end
      1: begin
        w[CFG_ADDR_W-1:0]                    = CFG_ADDR_W'(REG_FB);
        w[DIV_LSB +: CFG_DIV_W]              = CFG_DIV_W'(127);
        for (int n = 0; n < CFG_NUM_OUT; n++) begin
          w[OSEL_LSB + n*CFG_SEL_W +: CFG_SEL_W] = (n < 3) ? CFG_SEL_W'(n) : CFG_SEL_W'(3);
        end
        w[DIR_BIT]                           = 1'b1;
      end
      2: begin
        w[CFG_ADDR_W-1:0]                    = CFG_ADDR_W'(REG_MISC);
        w[PD_BIT]                            = 1'b1;
        w[SRST_BIT]                          = 1'b1;
        w[BG_BIT]                            = 1'b1;
      end
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/lecfg_shift.sv
module lecfg_shift #(
  parameter int WORD_W = 32
) (
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_le_n,
  output logic [WORD_W-1:0] cap_word,
  output logic              cap_tgl
);

  localparam int CNT_SAT = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_SAT + 1);

  logic              open_tgl_q;
  logic              seen_tgl_q, seen_tgl_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              first_bit;
  logic              frame_ok;
  logic [WORD_W-1:0] cap_word_d;
  logic              cap_tgl_d;

  // frame-open marker, flipped on every strobe falling edge
  always_ff @(negedge ser_le_n or negedge rst_n) begin
    if (!rst_n) open_tgl_q <= 1'b0;
    else        open_tgl_q <= ~open_tgl_q;
  end

  assign first_bit = (open_tgl_q != seen_tgl_q);

  always_comb begin
    sh_d       = sh_q;
    cnt_d      = cnt_q;
    seen_tgl_d = seen_tgl_q;
    if (!ser_le_n) begin
      sh_d       = {sh_q[WORD_W-2:0], ser_dat};
      seen_tgl_d = open_tgl_q;
      if (first_bit)                      cnt_d = CNT_W'(1);
      else if (cnt_q != CNT_W'(CNT_SAT))  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      cnt_q      <= '0;
      seen_tgl_q <= 1'b0;
    end else begin
      sh_q       <= sh_d;
      cnt_q      <= cnt_d;
      seen_tgl_q <= seen_tgl_d;
    end
  end

  // closing edge: keep the word only if this frame carried exactly WORD_W bits
  assign frame_ok   = !first_bit && (cnt_q == CNT_W'(WORD_W));
  assign cap_word_d = frame_ok ? sh_q : cap_word;
  assign cap_tgl_d  = cap_tgl ^ frame_ok;

  always_ff @(posedge ser_le_n or negedge rst_n) begin
    if (!rst_n) begin
      cap_word <= '0;
      cap_tgl  <= 1'b0;
    end else begin
      cap_word <= cap_word_d;
      cap_tgl  <= cap_tgl_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge ser_clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_SAT)); // R7

endmodule

// File: rtl/lecfg_sync.sv
module lecfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic pulse
);

  logic [STAGES:0] chain_q, chain_d;

  assign chain_d = {chain_q[STAGES-1:0], tgl_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign pulse = chain_q[STAGES] ^ chain_q[STAGES-1];

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse); // R9

endmodule

// File: rtl/lecfg_regs.sv
module lecfg_regs
  import lecfg_pkg::*;
#(
  parameter int WORD_W   = CFG_WORD_W,
  parameter int NUM_REGS = CFG_NUM_REGS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_pulse,
  input  logic [WORD_W-1:0]                 wr_word,
  output logic [NUM_REGS-1:0][WORD_W-1:0]   words
);

  localparam int ADDR_W = $clog2(NUM_REGS);

  logic [ADDR_W-1:0]               wr_addr;
  logic [NUM_REGS-1:0]             wr_vec;
  logic [NUM_REGS-1:0][WORD_W-1:0] word_d;

  assign wr_addr = wr_word[ADDR_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [WORD_W-1:0] RST_VAL = WORD_W'(cfg_default(i));

    assign wr_vec[i] = wr_pulse && (wr_addr == ADDR_W'(i));

    always_comb begin
      word_d[i] = words[i];
      if (wr_vec[i]) word_d[i] = wr_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[i] <= RST_VAL;
      else        words[i] <= word_d[i];
    end

    if (i != CFG_RSVD_IDX) begin : g_rsvd_chk
      AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_addr == ADDR_W'(CFG_RSVD_IDX)) |=> $stable(words[i])); // R6
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |=> $stable(words)); // R9

endmodule

// File: rtl/lecfg_port.sv
module lecfg_port
  import lecfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ser_clk,
  input  logic                             ser_dat,
  input  logic                             ser_le_n,
  output logic [CFG_DIV_W-1:0]             ref_div_code,
  output logic [CFG_DLY_W-1:0]             ref_dly,
  output logic [CFG_PW_W-1:0]              pw_code,
  output logic [CFG_PUMP_W-1:0]            pump_code,
  output logic [CFG_NUM_OUT-1:0]           out_en,
  output logic                             pump_en,
  output logic                             amp_en,
  output logic [CFG_SEL_W-1:0]             fb_sel,
  output logic [CFG_DIV_W-1:0]             fb_div_code,
  output logic [CFG_DLY_W-1:0]             fb_dly,
  output logic [CFG_NUM_OUT*CFG_SEL_W-1:0] out_sel,
  output logic                             pump_dir,
  output logic                             ext_res_en,
  output logic                             hold_en,
  output logic                             soft_pd_n,
  output logic                             soft_rst_n,
  output logic                             bg_en,
  output logic [CFG_LW_W-1:0]              lock_win
);

  logic [1:0]                               rst_pipe_q;
  logic                                     sys_rst_n;
  logic [CFG_WORD_W-1:0]                    cap_word;
  logic                                     cap_tgl;
  logic                                     upd_pulse;
  logic [CFG_NUM_REGS-1:0][CFG_WORD_W-1:0]  words;
  logic [CFG_WORD_W-1:0]                    w_ref, w_fb, w_misc;
  logic                                     unused_bits;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign sys_rst_n = rst_pipe_q[1];

  lecfg_shift #(.WORD_W(CFG_WORD_W)) u_shift (
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_dat  (ser_dat),
    .ser_le_n (ser_le_n),
    .cap_word (cap_word),
    .cap_tgl  (cap_tgl)
  );

  lecfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .tgl_in (cap_tgl),
    .pulse  (upd_pulse)
  );

  lecfg_regs #(.WORD_W(CFG_WORD_W), .NUM_REGS(CFG_NUM_REGS)) u_regs (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .wr_pulse (upd_pulse),
    .wr_word  (cap_word),
    .words    (words)
  );

  assign w_ref  = words[REG_REF];
  assign w_fb   = words[REG_FB];
  assign w_misc = words[REG_MISC];

  assign ref_div_code = w_ref[DIV_LSB +: CFG_DIV_W];
  assign ref_dly      = w_ref[DLY_LSB +: CFG_DLY_W];
  assign pw_code      = w_ref[PW_LSB +: CFG_PW_W];
  assign pump_code    = w_ref[PUMP_LSB +: CFG_PUMP_W];
  assign out_en       = w_ref[OE_LSB +: CFG_NUM_OUT];
  assign pump_en      = w_ref[PEN_BIT];
  assign amp_en       = w_ref[AEN_BIT];
  assign fb_sel       = w_ref[FBSEL_LSB +: CFG_SEL_W];

  assign fb_div_code  = w_fb[DIV_LSB +: CFG_DIV_W];
  assign fb_dly       = w_fb[DLY_LSB +: CFG_DLY_W];
  assign out_sel      = w_fb[OSEL_LSB +: CFG_NUM_OUT*CFG_SEL_W];
  assign pump_dir     = w_fb[DIR_BIT];
  assign ext_res_en   = w_fb[REXT_BIT];

  assign hold_en      = w_misc[HOLD_BIT];
  assign soft_pd_n    = w_misc[PD_BIT];
  assign soft_rst_n   = w_misc[SRST_BIT];
  assign bg_en        = w_misc[BG_BIT];
  assign lock_win     = w_misc[LW_LSB +: CFG_LW_W];

  assign unused_bits = ^{w_ref[CFG_ADDR_W-1:0], w_fb[CFG_ADDR_W-1:0],
                         w_misc[CFG_WORD_W-1:LW_LSB+CFG_LW_W], w_misc[CFG_ADDR_W-1:0],
                         words[CFG_RSVD_IDX]};

endmodule

// File: tb/lecfg_port_bench.sv
module lecfg_port_bench;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, ser_clk, ser_dat, ser_le_n;
  logic [9:0]  ref_div_code, fb_div_code;
  logic [2:0]  ref_dly, pw_code, fb_sel, fb_dly;
  logic [3:0]  pump_code;
  logic [4:0]  out_en;
  logic [14:0] out_sel;
  logic        pump_en, amp_en, pump_dir, ext_res_en;
  logic        hold_en, soft_pd_n, soft_rst_n, bg_en;
  logic [1:0]  lock_win;

  lecfg_port u_lecfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le_n(ser_le_n),
    .ref_div_code(ref_div_code), .ref_dly(ref_dly), .pw_code(pw_code), .pump_code(pump_code),
    .out_en(out_en), .pump_en(pump_en), .amp_en(amp_en), .fb_sel(fb_sel),
    .fb_div_code(fb_div_code), .fb_dly(fb_dly), .out_sel(out_sel), .pump_dir(pump_dir),
    .ext_res_en(ext_res_en), .hold_en(hold_en), .soft_pd_n(soft_pd_n),
    .soft_rst_n(soft_rst_n), .bg_en(bg_en), .lock_win(lock_win)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] mdl [3];

  task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
    end
  endtask

  // expected field values taken from the word layout in R2, R3, R4
  task automatic chk_all(input string tag);
    chk(tag, "ref_div_code", 32'(ref_div_code), 32'(mdl[0][11:2]));
    chk(tag, "ref_dly",      32'(ref_dly),      32'(mdl[0][14:12]));
    chk(tag, "pw_code",      32'(pw_code),      32'(mdl[0][17:15]));
    chk(tag, "pump_code",    32'(pump_code),    32'(mdl[0][21:18]));
    chk(tag, "out_en",       32'(out_en),       32'(mdl[0][26:22]));
    chk(tag, "pump_en",      32'(pump_en),      32'(mdl[0][27]));
    chk(tag, "amp_en",       32'(amp_en),       32'(mdl[0][28]));
    chk(tag, "fb_sel",       32'(fb_sel),       32'(mdl[0][31:29]));
    chk(tag, "fb_div_code",  32'(fb_div_code),  32'(mdl[1][11:2]));
    chk(tag, "fb_dly",       32'(fb_dly),       32'(mdl[1][14:12]));
    chk(tag, "out_sel",      32'(out_sel),      32'(mdl[1][29:15]));
    chk(tag, "pump_dir",     32'(pump_dir),     32'(mdl[1][30]));
    chk(tag, "ext_res_en",   32'(ext_res_en),   32'(mdl[1][31]));
    chk(tag, "hold_en",      32'(hold_en),      32'(mdl[2][2]));
    chk(tag, "soft_pd_n",    32'(soft_pd_n),    32'(mdl[2][3]));
    chk(tag, "soft_rst_n",   32'(soft_rst_n),   32'(mdl[2][4]));
    chk(tag, "bg_en",        32'(bg_en),        32'(mdl[2][5]));
    chk(tag, "lock_win",     32'(lock_win),     32'(mdl[2][7:6]));
  endtask

  task automatic ser_bit(input logic b);
    ser_dat = b; #10; ser_clk = 1'b1; #20; ser_clk = 1'b0; #10;
  endtask

  task automatic open_and_shift(input logic [63:0] v, input int n);
    ser_le_n = 1'b0; #20;
    for (int i = n - 1; i >= 0; i--) ser_bit(v[i]);
    #10;
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    open_and_shift(v, n);
    ser_le_n = 1'b1; #20;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic commit(input logic [31:0] w);
    send_bits({32'h0, w}, 32);
    if (w[1:0] != 2'd3) mdl[w[1:0]] = w;
    settle();
  endtask

  task automatic t_reset();
    // R1 defaults stated field by field
    chk("R1", "ref_div_code", 32'(ref_div_code), 32'd127);
    chk("R1", "fb_div_code",  32'(fb_div_code),  32'd127);
    chk("R1", "pump_code",    32'(pump_code),    32'd9);
    chk("R1", "out_en",       32'(out_en),       32'h1f);
    chk("R1", "fb_sel",       32'(fb_sel),       32'd3);
    chk("R1", "out_sel",      32'(out_sel),      32'({3'd3, 3'd3, 3'd2, 3'd1, 3'd0}));
    chk("R1", "misc_bits",    32'({hold_en, soft_pd_n, soft_rst_n, bg_en, lock_win}), 32'b011100);
    chk("R1", "flags",        32'({pump_en, amp_en, pump_dir, ext_res_en}), 32'b1010);
    chk_all("R1");
  endtask

  task automatic t_reg0();
    commit(32'hB3C9_5A74);
    chk_all("R2");
    commit(32'h4C36_A588);
    chk_all("R2_second_pattern");
    chk_all("R5");
  endtask

  task automatic t_reg1();
    commit(32'h6D1E_82C9);
    chk_all("R3");
    chk_all("R5");
  endtask

  task automatic t_reg2();
    commit(32'hFFFF_FF56);
    chk_all("R4");
    commit(32'h0000_00C2);
    chk_all("R4_asserted_low");
    commit(32'h0000_003A);
    chk_all("R4_restore");
  endtask

  task automatic t_reserved();
    commit(32'hFFFF_FFFF);
    chk_all("R6");
    commit(32'h0000_0003);
    chk_all("R6");
  endtask

  task automatic t_bad_length();
    send_bits({32'h0, 32'h1234_5678} >> 1, 31); settle(); chk_all("R7_31bits");
    send_bits({31'h0, 1'b1, 32'h8765_4320}, 33); settle(); chk_all("R7_33bits");
    send_bits(64'h0, 0); settle(); chk_all("R7_0bits");
  endtask

  task automatic t_clk_while_high();
    logic [31:0] w;
    w = 32'hDEAD_BEE0;
    for (int i = 31; i >= 0; i--) ser_bit(w[i]);
    settle();
    chk_all("R8_no_strobe");
    ser_le_n = 1'b0; #40; ser_le_n = 1'b1; #20;
    settle();
    chk_all("R8_empty_after");
  endtask

  task automatic t_timing();
    logic [31:0] old_ref, w;
    old_ref = mdl[0];
    w = 32'h2F0E_4C10;
    open_and_shift({32'h0, w}, 32);
    ser_le_n = 1'b1;
    @(negedge clk);
    chk("R9_early", "ref_div_code", 32'(ref_div_code), 32'(old_ref[11:2]));
    mdl[0] = w;
    repeat (6) @(negedge clk);
    chk_all("R9_late");
  endtask

  task automatic t_back_to_back();
    logic [31:0] wa, wb;
    wa = 32'h9137_6A05;
    wb = 32'h0000_0096;
    open_and_shift({32'h0, wa}, 32);
    ser_le_n = 1'b1; #20;
    open_and_shift({32'h0, wb}, 32);
    ser_le_n = 1'b1; #20;
    mdl[1] = wa;
    mdl[2] = wb;
    settle();
    chk_all("R10");
  endtask

  task automatic t_div_extremes();
    commit(32'h0000_0000);
    chk("R11_min", "ref_div_code", 32'(ref_div_code), 32'd0);
    commit(32'h0000_0FFD);
    chk("R11_max", "fb_div_code", 32'(fb_div_code), 32'd1023);
    chk_all("R11");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(64'd200000 * 8);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    mdl[0] = 32'h6FE4_01FC;
    mdl[1] = 32'h5B44_01FD;
    mdl[2] = 32'h0000_003A;
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_le_n = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_reg0();
    t_reg1();
    t_reg2();
    t_reserved();
    t_bad_length();
    t_clk_while_high();
    t_timing();
    t_back_to_back();
    t_div_extremes();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule